// File: doc/BRIEF.md
# One-shot pulse timer

This block is an up-counter with one compare channel. It is meant to produce a single timed pulse after a start command. Software programs a top-of-count value and a compare threshold through a small write port, then sets the run bit. The counter climbs from its current value one step per clock. After it reaches the top value it drops to zero and raises a one-clock update strobe. When the one-shot mode bit is set, that same wrap clears the run bit. The counter then parks at zero until it is started again.

The compare output is low while the count is below the threshold and high from the threshold up to the top value. A single run therefore yields one low-then-high waveform whose edge position and period are both programmable. When one-shot mode is off, the counter keeps wrapping and the compare output repeats every period. A debug-halt input freezes the count, but only while the freeze-permission bit of the control word is set.

Top module: `pulse_timer`

## Requirements
- R1: After reset the count is 0, the run flag is 0, the update strobe is 0 and the compare output is 0. The top value and the threshold both reset to all ones.
- R2: While the run flag is 1 and the counter is not frozen, the count rises by one on every clock edge until it equals the top value.
- R3: On the edge after the count equals the top value, the count becomes 0. The update strobe is 1 for exactly that one cycle, in which the count reads 0.
- R4: With the one-shot bit set, the wrap clears the run flag in the same edge. The count then stays at 0 and no further update strobe follows.
- R5: With the one-shot bit clear, the counter keeps running after each wrap, with period top value + 1.
- R6: The compare output equals 1 exactly when the count is greater than or equal to the threshold, in the same cycle.
- R7: When debug-halt is 1 and the freeze-permission bit is 1, the count holds its value and no wrap occurs. With the permission bit at 0, debug-halt has no effect.
- R8: Writing the control word with the run bit 1 while already running does not restart or disturb the count. Writing it with the run bit 0 stops the counter, which then holds its value.
- R9: The write port uses select 0 for the top value, 1 for the threshold and 2 for the control word. In the control word, bit 0 is run, bit 1 is one-shot and bit 2 is freeze permission. Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Register select (0 top, 1 threshold, 2 control, 3 none) |
| wr_data | input | W | Write data |
| dbg_halt | input | 1 | Debug halt request |
| count | output | W | Current counter value |
| running | output | 1 | Run flag |
| cmp_out | output | 1 | Compare output level |
| update | output | 1 | One-cycle wrap strobe |

## Verification
The bench sweeps small top values against every nearby threshold in one-shot mode and predicts each cycle arithmetically. A broken increment or a wrong top-value compare therefore shows as a wrong count within one clock of the fault. A run flag that fails to clear shows as a count of 1 on the cycle after the wrap instead of a parked 0. A misplaced compare edge shows in the same cycle as a mismatched compare output. Freeze and rewrite faults are caught by holding the counter frozen, or rewriting the control word, for a few cycles and checking that the count advances by exactly the number of unfrozen edges.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;
  typedef enum logic [1:0] {
    SEL_TOP     = 2'd0,
    SEL_THRESH  = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT     = 0;
  localparam int CTRL_ONESHOT_BIT = 1;
  localparam int CTRL_FREEZE_BIT  = 2;

  function automatic logic next_run(input logic cur, input logic ctrl_wr,
                                    input logic wr_run, input logic shot_end);
    if (shot_end) return 1'b0;
    if (ctrl_wr) return cur ? (cur & wr_run) : wr_run;
    return cur;
  endfunction
endpackage

// File: rtl/pulse_timer_regs.sv
module pulse_timer_regs
  import pulse_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         shot_end,
  output logic [W-1:0] top_val,
  output logic [W-1:0] thresh_val,
  output logic         run,
  output logic         oneshot,
  output logic         freeze_ok
);
  localparam logic [W-1:0] ALL_ONES = '1;

  reg_sel_e sel;
  logic     ctrl_wr;
  logic     top_wr;
  logic     thresh_wr;

  assign sel       = reg_sel_e'(wr_sel);
  assign ctrl_wr   = wr_en && (sel == SEL_CTRL);
  assign top_wr    = wr_en && (sel == SEL_TOP);
  assign thresh_wr = wr_en && (sel == SEL_THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_val    <= ALL_ONES;
      thresh_val <= ALL_ONES;
      run        <= 1'b0;
      oneshot    <= 1'b0;
      freeze_ok  <= 1'b0;
    end else begin
      if (top_wr)    top_val    <= wr_data;
      if (thresh_wr) thresh_val <= wr_data;
      if (ctrl_wr) begin
        oneshot   <= wr_data[CTRL_ONESHOT_BIT];
        freeze_ok <= wr_data[CTRL_FREEZE_BIT];
      end
      run <= next_run(run, ctrl_wr, wr_data[CTRL_RUN_BIT], shot_end);
    end
  end

  // R4: a one-shot wrap always leaves the run flag cleared
  a_r4_shot_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
    shot_end |=> !run);

  // R8: rewriting run=1 while running keeps the counter running
  a_r8_rewrite_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_wr && wr_data[CTRL_RUN_BIT] && !shot_end) |=> run);

  // R9: the unused select changes no register
  a_r9_none_sel_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE && !shot_end) |=>
      ($stable(top_val) && $stable(thresh_val) && $stable(run)));
endmodule

// File: rtl/pulse_timer_counter.sv
module pulse_timer_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         freeze_ok,
  input  logic         dbg_halt,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         update
);
  logic halted;
  logic advance;
  logic at_top;

  function automatic logic [W-1:0] step_count(input logic [W-1:0] c,
                                               input logic [W-1:0] t);
    return (c == t) ? '0 : c + 1'b1;
  endfunction

  assign halted  = dbg_halt & freeze_ok;
  assign advance = run & ~halted;
  assign at_top  = (cnt == top_val);
  assign wrap    = advance & at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      update <= 1'b0;
    end else begin
      if (advance) cnt <= step_count(cnt, top_val);
      update <= wrap;
    end
  end

  // R2: single-step increment below the top value
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_top) |=> (cnt == $past(cnt) + 1'b1));

  // R3: wrap goes to zero and strobes update
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0 && update));

  a_r3_update_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> (cnt == '0));

  // R7: frozen counter holds
  a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && freeze_ok) |=> ($stable(cnt) && !update));

  // R8: stopped counter holds
  a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: rtl/pulse_timer_compare.sv
module pulse_timer_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] thresh_val,
  output logic         level
);
  function automatic logic ref_level(input logic [W-1:0] c,
                                     input logic [W-1:0] th);
    return c >= th;
  endfunction

  assign level = ref_level(cnt, thresh_val);

  // R6: with a fixed threshold the output can only rise where the count meets it
  a_r6_rise_at_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(level) && $stable(thresh_val)) |-> (cnt == thresh_val));

  // R6: with a fixed threshold the output can only fall on a return to zero
  a_r6_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(level) && $stable(thresh_val)) |-> (cnt == '0));
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import pulse_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         dbg_halt,
  output logic [W-1:0] count,
  output logic         running,
  output logic         cmp_out,
  output logic         update
);
  logic [W-1:0] top_val;
  logic [W-1:0] thresh_val;
  logic         run;
  logic         oneshot;
  logic         freeze_ok;
  logic         wrap;
  logic         shot_end;
  logic [W-1:0] cnt;

  assign shot_end = wrap & oneshot;

  pulse_timer_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .shot_end   (shot_end),
    .top_val    (top_val),
    .thresh_val (thresh_val),
    .run        (run),
    .oneshot    (oneshot),
    .freeze_ok  (freeze_ok)
  );

  pulse_timer_counter #(.W(W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .freeze_ok (freeze_ok),
    .dbg_halt  (dbg_halt),
    .top_val   (top_val),
    .cnt       (cnt),
    .wrap      (wrap),
    .update    (update)
  );

  pulse_timer_compare #(.W(W)) u_compare (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .thresh_val (thresh_val),
    .level      (cmp_out)
  );

  assign count   = cnt;
  assign running = run;

  // R5: in continuous mode a wrap leaves the counter running
  a_r5_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !oneshot && !(wr_en && wr_sel == SEL_CTRL)) |=> running);
endmodule

// File: tb/tb_pulse_timer.sv
module tb_pulse_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       dbg_halt;
  logic [7:0] count;
  logic       running;
  logic       cmp_out;
  logic       update;

  int total = 0;
  int failed = 0;
  int cur_th = 255;

  always #2 clk = ~clk;

  pulse_timer #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dbg_halt(dbg_halt), .count(count),
    .running(running), .cmp_out(cmp_out), .update(update)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic look(input string tag, input int ec, input int eu, input int er);
    chk(tag, "count", int'(count), ec);
    chk(tag, "update", int'(update), eu);
    chk(tag, "running", int'(running), er);
    chk("R6", "cmp_out", int'(cmp_out), (ec >= cur_th) ? 1 : 0);
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0; dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("R1", 0, 0, 0);

    // R9: select 3 writes nothing (would start the counter if decoded as control)
    wr(2'd3, 8'h07);
    tick();
    look("R9", 0, 0, 0);

    // R2 R3 R4 R6: one-shot sweep over top values and thresholds
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 8; c++) begin
        wr(2'd0, 8'(r));
        wr(2'd1, 8'(c));
        cur_th = c;
        wr(2'd2, 8'h03);
        for (int j = 0; j <= r + 2; j++) begin
          if (j > 0) tick();
          if (j <= r)          look("R2", j, 0, 1);
          else if (j == r + 1) look("R3 R4", 0, 1, 0);
          else                 look("R4", 0, 0, 0);
        end
      end
    end

    // R5: continuous mode, top 4, threshold 2
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd2);
    cur_th = 2;
    wr(2'd2, 8'h01);
    look("R5", 0, 0, 1);
    for (int j = 1; j < 12; j++) begin
      tick();
      look("R5", j % 5, (j % 5 == 0) ? 1 : 0, 1);
    end
    // R8: rewrite run=1 while running: count continues
    wr(2'd2, 8'h01);
    look("R8", 12 % 5, 0, 1);
    tick();
    look("R8", 13 % 5, 0, 1);
    // R8: run=0 stops; value holds
    wr(2'd2, 8'h00);
    look("R8", 14 % 5, 0, 0);
    tick();
    look("R8", 4, 0, 0);
    tick();
    look("R8", 4, 0, 0);

    // R7: freeze with permission, from count 4, top 9
    wr(2'd0, 8'd9);
    wr(2'd1, 8'd9);
    cur_th = 9;
    wr(2'd2, 8'h05);
    look("R7", 4, 0, 1);
    for (int j = 1; j <= 3; j++) begin
      tick();
      look("R7", 4 + j, 0, 1);
    end
    dbg_halt = 1'b1;
    for (int j = 0; j < 3; j++) begin
      tick();
      look("R7", 7, 0, 1);
    end
    dbg_halt = 1'b0;
    tick();
    look("R7", 8, 0, 1);
    // permission off: halt ignored, count runs through the wrap
    wr(2'd2, 8'h01);
    look("R7", 9, 0, 1);
    dbg_halt = 1'b1;
    tick();
    look("R7 R5", 0, 1, 1);
    tick();
    look("R7", 1, 0, 1);
    dbg_halt = 1'b0;
    wr(2'd2, 8'h00);
    look("R8", 2, 0, 0);
    tick();
    look("R8", 2, 0, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule